// File: doc/BRIEF.md
# Fixed-Point Rounding and Overflow Stage

This block narrows a wide signed fixed-point word to a short output word in a single registered step. The caller supplies the wide value together with a binary point position `p`. The block removes the `p` lowest bits under a rounding rule chosen at build time. It then brings the result into the output range, either by clamping it or by keeping only the low bits. The output word can be read as signed or as unsigned. The rounding rule, the overflow rule and the output signedness are parameters; only the point position can change from word to word.

Data moves on a valid/ready stream on both sides, and the only storage is one output register. A word is accepted on a rising clock edge when `in_valid` and `in_ready` are both high. It appears on `out_data`, with `out_valid` high, after that same edge. `in_ready` is high whenever the output register is empty or is being drained in the current cycle (`out_ready` high). While `out_valid` is high and `out_ready` is low, the held word and `out_valid` stay unchanged and no new word is taken.

Top module: `fxr_reduce`

## Requirements
- R1: With `RND = RND_TRUNC`, the result is the input shifted right arithmetically by `p` bits. The discarded bits apply no correction, so the result is the floor of value / 2^p.
- R2: In every rounding mode other than `RND_TRUNC`, a discarded fraction above one half rounds up and a fraction below one half rounds down.
- R3: With `RND = RND_HALF_UP`, an exact half rounds toward positive infinity: 2.5 gives 3 and -2.5 gives -2.
- R4: With `RND = RND_HALF_AWAY`, an exact half rounds away from zero: 2.5 gives 3 and -2.5 gives -3.
- R5: With `RND = RND_HALF_ZERO`, an exact half rounds toward zero: 2.5 gives 2 and -2.5 gives -2.
- R6: With `RND = RND_HALF_EVEN`, an exact half rounds to the even neighbour: 2.5 gives 2, 3.5 gives 4, -2.5 gives -2 and -3.5 gives -4.
- R7: With `OVF = OVF_SAT` and a signed output, a result above 2^(OUT_W-1)-1 becomes that value, and a result below -2^(OUT_W-1) becomes that value.
- R8: With `OVF = OVF_SAT` and an unsigned output, any negative result becomes 0 and a result above 2^OUT_W-1 becomes all ones.
- R9: With `OVF = OVF_WRAP`, an out-of-range result is emitted as its low `OUT_W` bits in two's complement, with no correction.
- R10: `in_point` = 0 removes no bits. An in-range input then passes through unchanged in every rounding mode. `in_point` values above `MAX_PT` act as `MAX_PT`.
- R11: A word accepted on a clock edge is on `out_data`, with `out_valid` high, after that edge. With no new word and `out_ready` high, `out_valid` falls after the next edge.
- R12: While `out_valid` is high and `out_ready` is low, `in_ready` is low, and `out_data` and `out_valid` hold their values.
- R13: During and right after reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An input word is offered |
| in_ready | output | 1 | The stage can take a word this cycle |
| in_data | input | IN_W | Wide signed two's complement value |
| in_point | input | PT_W | Number of low bits to round away (0..MAX_PT) |
| out_valid | output | 1 | `out_data` holds a result |
| out_ready | input | 1 | The consumer takes the result this cycle |
| out_data | output | OUT_W | Narrowed result, signed or unsigned per `OUT_SIGNED` |

## Verification
The bench builds all twenty combinations of rounding rule, overflow rule and output signedness in a small 8-to-4-bit configuration. It drives every input value at every point position into all twenty at once, so every exact tie is covered: positive and negative, odd and even quotient, and the ties at -0.5 and +0.5 that straddle zero. A tie rule applied to the wrong sign would show up as -2.5 landing on -3 where -2 is required, or the reverse. Treating a value just above half as a tie, or the reverse, would show up on values whose low bits differ from the half pattern only below the guard bit. The swept values also cross every clamp boundary, so a rounded carry that overflows unnoticed (7.5 saturating to 7, or wrapping to -8) or an unsigned stage that lets a negative result wrap instead of clamping to 0 would give a visibly wrong code. A short stall sequence checks that a refused word is neither lost nor overwritten while the output is held.

// File: rtl/fxr_pkg.sv
package fxr_pkg;

  typedef enum logic [2:0] {
    RND_TRUNC     = 3'd0,
    RND_HALF_UP   = 3'd1,
    RND_HALF_AWAY = 3'd2,
    RND_HALF_ZERO = 3'd3,
    RND_HALF_EVEN = 3'd4
  } rnd_mode_e;

  typedef enum logic {
    OVF_SAT  = 1'b0,
    OVF_WRAP = 1'b1
  } ovf_mode_e;

endpackage

// File: rtl/fxr_shift.sv
// Variable arithmetic right shift that also reports the guard bit
// (weight one half) and a sticky OR of everything below it.
module fxr_shift #(
  parameter int IN_W   = 24,
  parameter int MAX_PT = 15,
  parameter int PT_W   = 4
) (
  input  logic [IN_W-1:0] x,
  input  logic [PT_W-1:0] pt,
  output logic [IN_W-1:0] q,
  output logic            guard,
  output logic            sticky
);

  localparam int NSEL = MAX_PT + 1;

  logic [IN_W-1:0] q_a [NSEL];
  logic            g_a [NSEL];
  logic            s_a [NSEL];
  logic [PT_W-1:0] sel;

  for (genvar k = 0; k < NSEL; k++) begin : g_pos
    assign q_a[k] = IN_W'($signed(x) >>> k);
    if (k == 0) begin : g_k0
      assign g_a[k] = 1'b0;
      assign s_a[k] = 1'b0;
    end else if (k == 1) begin : g_k1
      assign g_a[k] = x[0];
      assign s_a[k] = 1'b0;
    end else begin : g_kn
      assign g_a[k] = x[k-1];
      assign s_a[k] = |x[k-2:0];
    end
  end

  always_comb begin
    if (32'(pt) > MAX_PT) sel = PT_W'(MAX_PT);
    else                  sel = pt;
  end

  assign q      = q_a[sel];
  assign guard  = g_a[sel];
  assign sticky = s_a[sel];

endmodule

// File: rtl/fxr_round.sv
// Decides the increment from guard/sticky and the tie rule; output is one
// bit wider than the input so that the increment can never overflow.
module fxr_round
  import fxr_pkg::*;
#(
  parameter int        IN_W = 24,
  parameter rnd_mode_e RND  = RND_HALF_EVEN,
  localparam int       R_W  = IN_W + 1
) (
  input  logic [IN_W-1:0] q,
  input  logic            guard,
  input  logic            sticky,
  input  logic            neg,
  output logic [R_W-1:0]  r
);

  logic above, tie, tie_up, inc;

  assign above = guard & sticky;
  assign tie   = guard & ~sticky;

  always_comb begin
    unique case (RND)
      RND_HALF_UP:   tie_up = 1'b1;
      RND_HALF_AWAY: tie_up = ~neg;
      RND_HALF_ZERO: tie_up = neg;
      RND_HALF_EVEN: tie_up = q[0];
      default:       tie_up = 1'b0;
    endcase
  end

  assign inc = (RND == RND_TRUNC) ? 1'b0 : (above | (tie & tie_up));
  assign r   = {q[IN_W-1], q} + {{IN_W{1'b0}}, inc};

endmodule

// File: rtl/fxr_clip.sv
// Brings the rounded value into the output range by clamping or wrapping.
module fxr_clip
  import fxr_pkg::*;
#(
  parameter int        IN_W       = 24,
  parameter int        OUT_W      = 10,
  parameter bit        OUT_SIGNED = 1'b1,
  parameter ovf_mode_e OVF        = OVF_SAT,
  localparam int       R_W        = IN_W + 1
) (
  input  logic [R_W-1:0]   r,
  output logic [OUT_W-1:0] y
);

  logic hi_ovf, lo_ovf;
  logic [OUT_W-1:0] pos_lim, neg_lim;

  if (OUT_SIGNED) begin : g_sgn
    logic [R_W-OUT_W:0] top;
    assign top     = r[R_W-1:OUT_W-1];
    assign hi_ovf  = ~r[R_W-1] & (|top);
    assign lo_ovf  = r[R_W-1] & ~(&top);
    assign pos_lim = {1'b0, {(OUT_W-1){1'b1}}};
    assign neg_lim = {1'b1, {(OUT_W-1){1'b0}}};
  end else begin : g_uns
    assign hi_ovf  = ~r[R_W-1] & (|r[R_W-2:OUT_W]);
    assign lo_ovf  = r[R_W-1];
    assign pos_lim = {OUT_W{1'b1}};
    assign neg_lim = '0;
  end

  if (OVF == OVF_SAT) begin : g_sat
    always_comb begin
      if (hi_ovf)      y = pos_lim;
      else if (lo_ovf) y = neg_lim;
      else             y = r[OUT_W-1:0];
    end
  end else begin : g_wrap
    assign y = r[OUT_W-1:0];
  end

endmodule

// File: rtl/fxr_reduce.sv
module fxr_reduce
  import fxr_pkg::*;
#(
  parameter int        IN_W       = 24,
  parameter int        OUT_W      = 10,
  parameter int        MAX_PT     = 15,
  parameter int        PT_W       = $clog2(MAX_PT + 1),
  parameter rnd_mode_e RND        = RND_HALF_EVEN,
  parameter ovf_mode_e OVF        = OVF_SAT,
  parameter bit        OUT_SIGNED = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [IN_W-1:0]  in_data,
  input  logic [PT_W-1:0]  in_point,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [OUT_W-1:0] out_data
);

  localparam int R_W = IN_W + 1;

  if (OUT_W >= IN_W || MAX_PT >= IN_W || (1 << PT_W) < MAX_PT + 1) begin : g_bad_cfg
    initial $error("fxr_reduce: bad width parameters");
  end

  logic [IN_W-1:0]  q;
  logic             guard, sticky;
  logic [R_W-1:0]   r;
  logic [OUT_W-1:0] y;
  logic             take;
  logic             vld_q;
  logic [OUT_W-1:0] dat_q;

  fxr_shift #(.IN_W(IN_W), .MAX_PT(MAX_PT), .PT_W(PT_W)) u_shift (
    .x(in_data), .pt(in_point), .q(q), .guard(guard), .sticky(sticky)
  );

  fxr_round #(.IN_W(IN_W), .RND(RND)) u_round (
    .q(q), .guard(guard), .sticky(sticky), .neg(in_data[IN_W-1]), .r(r)
  );

  fxr_clip #(.IN_W(IN_W), .OUT_W(OUT_W), .OUT_SIGNED(OUT_SIGNED), .OVF(OVF)) u_clip (
    .r(r), .y(y)
  );

  assign in_ready = ~vld_q | out_ready;
  assign take     = in_valid & in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else if (take) begin
      vld_q <= 1'b1;
      dat_q <= y;
    end else if (out_ready) begin
      vld_q <= 1'b0;
    end
  end

  assign out_valid = vld_q;
  assign out_data  = dat_q;

endmodule

// File: rtl/fxr_reduce_chk.sv
module fxr_reduce_chk
  import fxr_pkg::*;
#(
  parameter int        IN_W       = 24,
  parameter int        OUT_W      = 10,
  parameter int        PT_W       = 4,
  parameter ovf_mode_e OVF        = OVF_SAT,
  parameter bit        OUT_SIGNED = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [IN_W-1:0]  in_data,
  input logic [PT_W-1:0]  in_point,
  input logic             out_valid,
  input logic             out_ready,
  input logic [OUT_W-1:0] out_data
);

  localparam int LO = OUT_SIGNED ? -(1 << (OUT_W - 1)) : 0;
  localparam int HI = OUT_SIGNED ? (1 << (OUT_W - 1)) - 1 : (1 << OUT_W) - 1;

  logic take, fits;
  assign take = in_valid & in_ready;
  assign fits = ($signed(in_data) >= LO) && ($signed(in_data) <= HI);

  // R12: stalled output keeps its word and stays valid
  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  // R11: an accepted word is presented after the edge
  p_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid);

  // R11: output empties when drained with nothing new
  p_drain_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid && (out_ready || !out_valid) |=> !out_valid);

  // R10: point zero with an in-range value passes through
  p_pass_r10: assert property (@(posedge clk) disable iff (!rst_n)
    take && in_point == '0 && fits |=> out_data == $past(in_data[OUT_W-1:0]));

  if (!OUT_SIGNED && OVF == OVF_SAT) begin : g_uns_sat
    // R8: negative whole value clamps to zero on an unsigned output
    p_neg_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      take && in_point == '0 && in_data[IN_W-1] |=> out_data == '0);
  end

endmodule

bind fxr_reduce fxr_reduce_chk #(
  .IN_W(IN_W), .OUT_W(OUT_W), .PT_W(PT_W), .OVF(OVF), .OUT_SIGNED(OUT_SIGNED)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_data(in_data), .in_point(in_point), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data)
);

// File: tb/sim_fxr_reduce.sv
module sim_fxr_reduce;
  import fxr_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int IN_W   = 8;
  localparam int OUT_W  = 4;
  localparam int MAX_PT = 3;
  localparam int PT_W   = 2;
  localparam int NCFG   = 20;
  localparam int WD_CYC = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic out_ready = 1'b0;
  logic [IN_W-1:0] in_data = '0;
  logic [PT_W-1:0] in_point = '0;
  logic             o_rdy [NCFG];
  logic             o_vld [NCFG];
  logic [OUT_W-1:0] o_dat [NCFG];

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // config i: rounding rule i%5, overflow (i/5)%2, signed when i<10
  for (genvar i = 0; i < NCFG; i++) begin : g_cfg
    localparam rnd_mode_e RM = rnd_mode_e'(i % 5);
    localparam ovf_mode_e OM = ovf_mode_e'((i / 5) % 2);
    localparam bit        SG = (i < 10);
    fxr_reduce #(.IN_W(IN_W), .OUT_W(OUT_W), .MAX_PT(MAX_PT), .PT_W(PT_W),
                 .RND(RM), .OVF(OM), .OUT_SIGNED(SG)) u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(o_rdy[i]),
      .in_data(in_data), .in_point(in_point), .out_valid(o_vld[i]),
      .out_ready(out_ready), .out_data(o_dat[i])
    );
  end

  // Reference: returns the exact result code and the requirement it exercises.
  function automatic int model(int v, int p, int cfg, output string tag);
    int rnd = cfg % 5;
    bit sat = ((cfg / 5) % 2) == 0;
    bit sgn = cfg < 10;
    int q = v >>> p;
    int rem = v - q * (1 << p);
    int half = (p > 0) ? (1 << (p - 1)) : 0;
    int r = q;
    int lo = sgn ? -(1 << (OUT_W - 1)) : 0;
    int hi = sgn ? (1 << (OUT_W - 1)) - 1 : (1 << OUT_W) - 1;
    bit tie = 0;
    if (p > 0 && rnd != 0) begin
      if (rem > half) r = q + 1;
      else if (rem == half) begin
        tie = 1;
        case (rnd)
          1: r = q + 1;
          2: r = (v < 0) ? q : q + 1;
          3: r = (v < 0) ? q + 1 : q;
          default: r = ((q & 1) == 0) ? q : q + 1;
        endcase
      end
    end
    if (r > hi || r < lo) begin
      if (sat) begin
        tag = sgn ? "R7" : "R8";
        r = (r > hi) ? hi : lo;
      end else tag = "R9";
    end else if (p == 0) tag = "R10";
    else if (rnd == 0) tag = "R1";
    else if (!tie) tag = "R2";
    else case (rnd)
      1: tag = "R3";
      2: tag = "R4";
      3: tag = "R5";
      default: tag = "R6";
    endcase
    return r & ((1 << OUT_W) - 1);
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic check_all(int v, int p);
    for (int i = 0; i < NCFG; i++) begin
      string tag;
      int e = model(v, p, i, tag);
      chk(o_vld[i] === 1'b1, "R11", $sformatf("cfg%0d valid v=%0d p=%0d", i, v, p), int'(o_vld[i]), 1);
      chk(int'(o_dat[i]) == e, tag, $sformatf("cfg%0d data v=%0d p=%0d", i, v, p), int'(o_dat[i]), e);
    end
  endtask

  task automatic drive(int v, int p);
    in_valid = 1'b1;
    in_data  = IN_W'(v);
    in_point = PT_W'(p);
  endtask

  initial begin
    repeat (WD_CYC) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    string t0;
    int e0;
    repeat (3) @(negedge clk);
    // R13: reset state
    for (int i = 0; i < NCFG; i++) begin
      chk(o_vld[i] === 1'b0, "R13", $sformatf("cfg%0d out_valid in reset", i), int'(o_vld[i]), 0);
      chk(o_rdy[i] === 1'b1, "R13", $sformatf("cfg%0d in_ready in reset", i), int'(o_rdy[i]), 1);
    end
    rst_n = 1'b1;
    @(negedge clk);
    chk(o_vld[0] === 1'b0, "R13", "out_valid after reset", int'(o_vld[0]), 0);

    // Exhaustive sweep, full throughput; covers R1..R10 and R11
    out_ready = 1'b1;
    for (int p = 0; p <= MAX_PT; p++) begin
      for (int v = -128; v < 128; v++) begin
        drive(v, p);
        @(negedge clk);
        check_all(v, p);
        chk(o_rdy[0] === 1'b1, "R12", "in_ready with out_ready high", int'(o_rdy[0]), 1);
      end
    end

    // R11: drain with nothing offered
    in_valid = 1'b0;
    @(negedge clk);
    chk(o_vld[0] === 1'b0, "R11", "valid drops after drain", int'(o_vld[0]), 0);

    // R12: stall holds the word and refuses the next
    out_ready = 1'b0;
    drive(37, 2);
    @(negedge clk);
    e0 = model(37, 2, 0, t0);
    chk(o_vld[0] === 1'b1, "R12", "stall valid", int'(o_vld[0]), 1);
    chk(o_rdy[0] === 1'b0, "R12", "in_ready low while stalled", int'(o_rdy[0]), 0);
    drive(-90, 1);
    repeat (2) @(negedge clk);
    chk(int'(o_dat[0]) == e0, "R12", "held word under stall", int'(o_dat[0]), e0);
    chk(o_vld[0] === 1'b1, "R12", "valid held under stall", int'(o_vld[0]), 1);
    out_ready = 1'b1;
    @(negedge clk);
    e0 = model(-90, 1, 0, t0);
    chk(int'(o_dat[0]) == e0, "R12", "refused word taken after release", int'(o_dat[0]), e0);
    in_valid = 1'b0;
    @(negedge clk);
    chk(o_vld[0] === 1'b0, "R11", "valid drops at end", int'(o_vld[0]), 0);

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule